// File: doc/BRIEF.md
# Strobe Window Center Calculator

This block works out the tap position at which a write strobe should be placed after an edge-detection scan has run. The scan sweeps a delay line and, for each of four transition kinds, reports whether it saw that transition and at which tap. The four kinds are unstable-to-zero, zero-to-unstable, unstable-to-one and one-to-unstable. The calculator also receives the left and right scan limits and the number of taps that make up 90 degrees of phase.

On a `start` pulse the block looks at which transitions were found and picks an averaging rule. The rule takes the midpoint of two positions, or of a position and a scan limit. Some rules then take off a 90-degree or 180-degree phase offset, expressed in taps. The result is clamped to the scan window and registered. One cycle later the block reports either a valid target or an error for a flag pattern it does not recognise. Running the scan and moving the taps are the job of the surrounding calibration logic.

Top module: `strobe_center_calc`

## Requirements
- R1: With found flags `edge_found` = 4'b0111 (bit 0 unstable-to-zero, bit 1 zero-to-unstable, bit 2 unstable-to-one, bit 3 one-to-unstable), the raw target is (pos_uz + pos_zu) >> 1.
- R2: With `edge_found` = 4'b1110, the raw target is ((pos_zu + pos_uo) >> 1) - taps_q90.
- R3: With `edge_found` = 4'b1100, the raw target is ((pos_uo + pos_ou) >> 1) - 2*taps_q90.
- R4: With `edge_found` = 4'b0001, the raw target is (pos_uz + lim_right) >> 1.
- R5: With `edge_found` = 4'b0010, the raw target is (lim_left + pos_zu) >> 1.
- R6: With `edge_found` = 4'b0100, the raw target is ((pos_uo + lim_right) >> 1) - 2*taps_q90.
- R7: Each midpoint is the full-width sum of its two operands shifted right by one, so an odd sum rounds down.
- R8: The reported target is min(lim_right, max(lim_left, raw)), where raw is a signed value. A negative raw result therefore gives lim_left and never wraps.
- R9: Any `edge_found` value other than the six listed above raises `center_err` instead of `center_valid`, and `center_tap` is driven to 0.
- R10: Exactly one of `center_valid` or `center_err` is high in the cycle after `start`, for that one cycle only. Both stay low in cycles that do not follow a `start`, and `center_tap` keeps its value.
- R11: After reset, `center_tap`, `center_valid` and `center_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Compute request, sampled on the rising edge |
| edge_found | input | 4 | Transition-found flags (bit order as in R1) |
| pos_uz | input | TAP_W | Unstable-to-zero tap |
| pos_zu | input | TAP_W | Zero-to-unstable tap |
| pos_uo | input | TAP_W | Unstable-to-one tap |
| pos_ou | input | TAP_W | One-to-unstable tap |
| lim_left | input | TAP_W | Left scan limit |
| lim_right | input | TAP_W | Right scan limit |
| taps_q90 | input | TAP_W | Taps per 90 degrees |
| center_tap | output | TAP_W | Registered target tap |
| center_valid | output | 1 | Target valid pulse |
| center_err | output | 1 | Unsupported pattern pulse |

## Verification
The hardest situation to reach is the subtraction of a phase offset that drives the raw result below zero or below the left limit. In that case the clamp must act on a signed value and must not act on a wrapped unsigned one. Random positions rarely combine small midpoints with large offsets, so directed cases pair low positions with `taps_q90` near its maximum for each offset rule. Random stimulus also narrows the scan window on some draws, so that both clamp bounds are exercised.

// File: rtl/scc_pkg.sv
package scc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_LO_PAIR = 3'd1,
    SEL_MID_Q90 = 3'd2,
    SEL_HI_H180 = 3'd3,
    SEL_UZ_RLIM = 3'd4,
    SEL_LLIM_ZU = 3'd5,
    SEL_UO_R180 = 3'd6
  } sel_e;

endpackage

// File: rtl/scc_classify.sv
module scc_classify
  import scc_pkg::*;
(
  input  logic [3:0] edge_found,
  output sel_e       sel
);

  always_comb begin
    case (edge_found)
      4'b0111: sel = SEL_LO_PAIR;
      4'b1110: sel = SEL_MID_Q90;
      4'b1100: sel = SEL_HI_H180;
      4'b0001: sel = SEL_UZ_RLIM;
      4'b0010: sel = SEL_LLIM_ZU;
      4'b0100: sel = SEL_UO_R180;
      default: sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/scc_arith.sv
module scc_arith
  import scc_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  sel_e              sel,
  input  logic [TAP_W-1:0]  pos_uz,
  input  logic [TAP_W-1:0]  pos_zu,
  input  logic [TAP_W-1:0]  pos_uo,
  input  logic [TAP_W-1:0]  pos_ou,
  input  logic [TAP_W-1:0]  lim_left,
  input  logic [TAP_W-1:0]  lim_right,
  input  logic [TAP_W-1:0]  taps_q90,
  output logic [TAP_W-1:0]  result
);

  localparam int SW = TAP_W + 3;

  logic [TAP_W-1:0]    opa, opb;
  logic [TAP_W:0]      sum;
  logic [TAP_W+1:0]    off;
  logic signed [SW-1:0] raw, left_s, right_s, lo_cl, hi_cl;

  // operand and offset selection
  always_comb begin
    opa = '0;
    opb = '0;
    off = '0;
    case (sel)
      SEL_LO_PAIR: begin opa = pos_uz;   opb = pos_zu;    end
      SEL_MID_Q90: begin opa = pos_zu;   opb = pos_uo;    off = {2'b00, taps_q90}; end
      SEL_HI_H180: begin opa = pos_uo;   opb = pos_ou;    off = {1'b0, taps_q90, 1'b0}; end
      SEL_UZ_RLIM: begin opa = pos_uz;   opb = lim_right; end
      SEL_LLIM_ZU: begin opa = lim_left; opb = pos_zu;    end
      SEL_UO_R180: begin opa = pos_uo;   opb = lim_right; off = {1'b0, taps_q90, 1'b0}; end
      default:     begin opa = '0;       opb = '0;        end
    endcase
  end

  // truncating midpoint, signed offset, window clamp
  always_comb begin
    sum     = {1'b0, opa} + {1'b0, opb};
    raw     = signed'({3'b000, sum[TAP_W:1]}) - signed'({1'b0, off});
    left_s  = signed'({3'b000, lim_left});
    right_s = signed'({3'b000, lim_right});
    lo_cl   = (raw < left_s) ? left_s : raw;
    hi_cl   = (lo_cl > right_s) ? right_s : lo_cl;
    result  = hi_cl[TAP_W-1:0];
  end

endmodule

// File: rtl/strobe_center_calc.sv
module strobe_center_calc
  import scc_pkg::*;
#(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [3:0]       edge_found,
  input  logic [TAP_W-1:0] pos_uz,
  input  logic [TAP_W-1:0] pos_zu,
  input  logic [TAP_W-1:0] pos_uo,
  input  logic [TAP_W-1:0] pos_ou,
  input  logic [TAP_W-1:0] lim_left,
  input  logic [TAP_W-1:0] lim_right,
  input  logic [TAP_W-1:0] taps_q90,
  output logic [TAP_W-1:0] center_tap,
  output logic             center_valid,
  output logic             center_err
);

  sel_e             sel;
  logic [TAP_W-1:0] tgt;
  logic [TAP_W-1:0] tap_d, tap_q;
  logic             vld_d, vld_q, err_d, err_q;
  logic             known;

  scc_classify u_cls (
    .edge_found (edge_found),
    .sel        (sel)
  );

  scc_arith #(.TAP_W(TAP_W)) u_ar (
    .sel       (sel),
    .pos_uz    (pos_uz),
    .pos_zu    (pos_zu),
    .pos_uo    (pos_uo),
    .pos_ou    (pos_ou),
    .lim_left  (lim_left),
    .lim_right (lim_right),
    .taps_q90  (taps_q90),
    .result    (tgt)
  );

  // next state
  always_comb begin
    known = (sel != SEL_NONE);
    vld_d = start & known;
    err_d = start & ~known;
    tap_d = tap_q;
    if (start) tap_d = known ? tgt : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      tap_q <= tap_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign center_tap   = tap_q;
  assign center_valid = vld_q;
  assign center_err   = err_q;

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) start |=> (center_valid ^ center_err)); // R10
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !(center_valid || center_err)); // R10
  AST_HOLD_TAP: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(center_tap)); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) center_err |-> (center_tap == '0)); // R9
  AST_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && known && (lim_left <= lim_right)) |=>
    (center_tap >= $past(lim_left) && center_tap <= $past(lim_right))); // R8

endmodule

// File: tb/strobe_center_calc_tb.sv
module strobe_center_calc_tb;

  localparam int TAP_W = 6;
  localparam int TMAX  = (1 << TAP_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [3:0]       edge_found = '0;
  logic [TAP_W-1:0] pos_uz = '0, pos_zu = '0, pos_uo = '0, pos_ou = '0;
  logic [TAP_W-1:0] lim_left = '0, lim_right = '0, taps_q90 = '0;
  logic [TAP_W-1:0] center_tap;
  logic             center_valid, center_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;
  int seed_v;

  always #10 clk = ~clk;

  strobe_center_calc #(.TAP_W(TAP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .edge_found(edge_found),
    .pos_uz(pos_uz), .pos_zu(pos_zu), .pos_uo(pos_uo), .pos_ou(pos_ou),
    .lim_left(lim_left), .lim_right(lim_right), .taps_q90(taps_q90),
    .center_tap(center_tap), .center_valid(center_valid), .center_err(center_err)
  );

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'b0111: return "R1";
      4'b1110: return "R2";
      4'b1100: return "R3";
      4'b0001: return "R4";
      4'b0010: return "R5";
      4'b0100: return "R6";
      default: return "R9";
    endcase
  endfunction

  // expected target; ok=0 for unsupported pattern
  function automatic int exp_tap(input logic [3:0] f, output bit ok);
    int a, b, o, raw, lo;
    ok = 1; a = 0; b = 0; o = 0;
    case (f)
      4'b0111: begin a = pos_uz;   b = pos_zu;    end
      4'b1110: begin a = pos_zu;   b = pos_uo;    o = taps_q90; end
      4'b1100: begin a = pos_uo;   b = pos_ou;    o = 2 * taps_q90; end
      4'b0001: begin a = pos_uz;   b = lim_right; end
      4'b0010: begin a = lim_left; b = pos_zu;    end
      4'b0100: begin a = pos_uo;   b = lim_right; o = 2 * taps_q90; end
      default: ok = 0;
    endcase
    if (!ok) return 0;
    raw = (a + b) / 2 - o;               // R7 floor on non-negative sum
    lo  = (raw < int'(lim_left)) ? int'(lim_left) : raw;
    return (lo > int'(lim_right)) ? int'(lim_right) : lo;  // R8
  endfunction

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    n_run++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // drive at negedge, result sampled at following negedge (one register)
  task automatic run_one(input logic [3:0] f);
    bit ok;
    int e;
    int prev;
    edge_found = f;
    e = exp_tap(f, ok);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(center_valid == ok, req_of(f), "valid", int'(center_valid), int'(ok));
    check(center_err == !ok, ok ? "R10" : "R9", "err", int'(center_err), int'(!ok));
    check(int'(center_tap) == e, req_of(f), "tap", int'(center_tap), e);
    prev = center_tap;
    @(negedge clk);
    check(!center_valid && !center_err, "R10", "pulse width",
          int'({center_valid, center_err}), 0);
    check(int'(center_tap) == prev, "R10", "tap hold", int'(center_tap), prev);
  endtask

  task automatic set_pos(input int uz, input int zu, input int uo, input int ou,
                         input int l, input int r, input int q);
    pos_uz = uz[TAP_W-1:0]; pos_zu = zu[TAP_W-1:0];
    pos_uo = uo[TAP_W-1:0]; pos_ou = ou[TAP_W-1:0];
    lim_left = l[TAP_W-1:0]; lim_right = r[TAP_W-1:0]; taps_q90 = q[TAP_W-1:0];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    seed_v = 32'h5EED_0C4A;
    void'($urandom(seed_v));
    repeat (3) @(negedge clk);
    check(center_tap == 0 && !center_valid && !center_err, "R11", "reset state",
          int'({center_tap, center_valid, center_err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: each rule with odd sums (R7)
    set_pos(10, 21, 40, 51, 0, TMAX, 8);
    run_one(4'b0111);                       // R1: 31>>1=15
    run_one(4'b1110);                       // R2: 30-8=22
    run_one(4'b1100);                       // R3: 45-16=29
    run_one(4'b0001);                       // R4: (10+63)>>1=36
    set_pos(10, 21, 40, 51, 4, TMAX, 8);
    run_one(4'b0010);                       // R5: 25>>1=12
    run_one(4'b0100);                       // R6: 51-16=35
    // R8: offset drives raw negative -> left limit
    set_pos(1, 2, 3, 4, 5, 60, TMAX);
    run_one(4'b1100);
    run_one(4'b1110);
    run_one(4'b0100);
    // R8: above right limit
    set_pos(60, 62, 63, 63, 0, 20, 0);
    run_one(4'b0111);
    // R9: unsupported patterns
    run_one(4'b0000);
    run_one(4'b1111);
    run_one(4'b1000);

    // random
    for (int i = 0; i < 600; i++) begin
      int l, r;
      l = $urandom_range(0, 20);
      r = ($urandom_range(0, 3) == 0) ? $urandom_range(l, 40) : TMAX;
      set_pos($urandom_range(0, TMAX), $urandom_range(0, TMAX),
              $urandom_range(0, TMAX), $urandom_range(0, TMAX),
              l, r, $urandom_range(0, 31));
      case ($urandom_range(0, 7))
        0: run_one(4'b0111);
        1: run_one(4'b1110);
        2: run_one(4'b1100);
        3: run_one(4'b0001);
        4: run_one(4'b0010);
        5: run_one(4'b0100);
        default: run_one(4'($urandom_range(0, 15)));
      endcase
      if ($urandom_range(0, 4) == 0) begin
        int hold;
        hold = center_tap;
        edge_found = 4'($urandom_range(0, 15));
        @(negedge clk);
        check(!center_valid && !center_err && int'(center_tap) == hold, "R10",
              "idle", int'(center_tap), hold);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule